// File: doc/BRIEF.md
# Sequential Stream Prefetcher

This block sits beside a cache and watches the addresses of its demand misses. Addresses are handled as 64-byte lines. When the misses walk upward through adjacent lines, the block starts to request the lines just ahead of the stream, so that they are already in flight when the program reaches them. It never asks for the same line twice within one stream. When the memory system is already saturated with demand misses, it stops issuing hardware prefetches.

Software prefetch hints enter on a separate port that never stalls. They are queued and forwarded on the same request port as the hardware prefetches, and they take precedence over them. The request port uses a valid/ready handshake and carries line-aligned byte addresses. A flag on the port tells which source each request came from.

Top module: `stream_prefetcher`

## Requirements
- R1: Every request on `pf_addr_o` is a byte address with bits [5:0] equal to zero. A demand address or hint address maps to line `addr >> 6`, and a request for line `n` carries address `n * 64`.
- R2: A stream is armed once `ARM_RUNS` (default 2) accesses in a row each land on the line one above the previous tracked line. Before that, no hardware request is made. The first hardware request after arming targets the tracked line plus one.
- R3: While a stream is armed, hardware requests cover the lines last+1 up to last+`PF_DIST` (default 4) in ascending order, each issued once. Each further sequential access moves this window up by one line, so exactly one new line is requested.
- R4: An access to any line other than the tracked line or the tracked line plus one clears the run, disarms the stream and makes that line the new tracked line. No further hardware request follows until the stream is re-armed.
- R5: An access to the line that is already tracked changes no state. It neither breaks nor advances the run.
- R6: While `miss_cnt_i` is at or above `BUSY_THRESH` (default 8), no hardware request is loaded onto the port. Requests that were held back go out once the count drops below the threshold.
- R7: A hint is accepted in any cycle without a stall. Up to `HINT_DEPTH` (default 4) hints wait in order behind the port. A hint that arrives while that queue is full is dropped. Hint requests carry `pf_is_sw_o` = 1, and hardware requests carry 0.
- R8: When a queued hint and a hardware request both wait for a free port, the hint is loaded first.
- R9: While `pf_valid_o` is high and `pf_ready_i` is low, the request is held, with address and source flag unchanged.
- R10: After reset, `pf_valid_o` is low and no stream is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dem_valid_i | input | 1 | Demand miss address valid |
| dem_addr_i | input | ADDR_W | Demand miss byte address |
| miss_cnt_i | input | MISS_W | Outstanding demand miss count |
| hint_valid_i | input | 1 | Software prefetch hint valid, never stalled |
| hint_addr_i | input | ADDR_W | Software prefetch hint byte address |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_ready_i | input | 1 | Prefetch request accepted |
| pf_addr_o | output | ADDR_W | Line-aligned prefetch byte address |
| pf_is_sw_o | output | 1 | Request came from a software hint |

## Verification
The hardest case to reach is a hint and a hardware request that wait at the same moment with the port busy, since a free port would take either one at once. The stimulus gets there in steps. It arms a stream while the miss count holds the hardware side in saturation, and it keeps ready low so that a first hint occupies the port. It then queues a second hint and releases the saturation, so both sources are pending when ready rises. The same stalled port also serves to fill the hint queue until a hint is dropped, and to watch the held request stay unchanged.

// File: rtl/stream_pf_pkg.sv
package stream_pf_pkg;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned LINE_OFF_W = $clog2(LINE_BYTES);

  typedef enum logic {
    SRC_HW = 1'b0,
    SRC_SW = 1'b1
  } pf_src_e;
endpackage

// File: rtl/pf_stream_tracker.sv
module pf_stream_tracker #(
  parameter int unsigned LINE_W   = 26,
  parameter int unsigned PF_DIST  = 4,
  parameter int unsigned ARM_RUNS = 2,
  localparam int unsigned AHEAD_W = $clog2(PF_DIST + 1),
  localparam int unsigned RUN_W   = $clog2(ARM_RUNS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [LINE_W-1:0]  acc_line_i,
  input  logic               take_i,
  output logic               armed_o,
  output logic [AHEAD_W-1:0] ahead_o,
  output logic [LINE_W-1:0]  next_line_o
);
  logic              trk_vld_q;
  logic [LINE_W-1:0] last_q;
  logic [RUN_W-1:0]  run_q;
  logic [AHEAD_W-1:0] ahead_q;

  logic is_seq, is_same, is_move;
  logic [AHEAD_W:0]   ahead_sum;
  logic [AHEAD_W-1:0] ahead_shift;

  assign is_same = acc_valid_i && trk_vld_q && (acc_line_i == last_q);
  assign is_seq  = acc_valid_i && trk_vld_q && (acc_line_i == last_q + LINE_W'(1));
  assign is_move = acc_valid_i && !is_same;

  assign armed_o     = (run_q == RUN_W'(ARM_RUNS));
  assign ahead_o     = ahead_q;
  assign next_line_o = last_q + LINE_W'(ahead_q) + LINE_W'(1);

  // window slides by one line per sequential access; a take in the same cycle adds one
  assign ahead_sum   = {1'b0, ahead_q} + {{AHEAD_W{1'b0}}, take_i};
  assign ahead_shift = (ahead_sum == '0) ? '0 : AHEAD_W'(ahead_sum - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_vld_q <= 1'b0;
      last_q    <= '0;
      run_q     <= '0;
      ahead_q   <= '0;
    end else if (is_move) begin
      trk_vld_q <= 1'b1;
      last_q    <= acc_line_i;
      if (is_seq) begin
        if (!armed_o) run_q <= run_q + RUN_W'(1);
        ahead_q <= armed_o ? ahead_shift : '0;
      end else begin
        run_q   <= '0;
        ahead_q <= '0;
      end
    end else if (take_i) begin
      ahead_q <= AHEAD_W'(ahead_sum);
    end
  end
endmodule

// File: rtl/pf_hint_fifo.sv
module pf_hint_fifo #(
  parameter int unsigned W     = 26,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] data_o
);
  logic [CNT_W-1:0] cnt_q;
  logic full, do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  // a hint meeting a full queue is dropped, never back-pressured
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (do_push && !do_pop) cnt_q <= cnt_q + CNT_W'(1);
    else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
  end

  generate
    if (DEPTH == 1) begin : g_single
      logic [W-1:0] slot_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q <= '0;
        else if (do_push) slot_q <= data_i;
      end
      assign data_o = slot_q;
    end else begin : g_ring
      logic [W-1:0]     mem_q [DEPTH];
      logic [PTR_W-1:0] wr_q, rd_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wr_q <= '0;
          rd_q <= '0;
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
          if (do_push) begin
            mem_q[wr_q] <= data_i;
            wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
          end
          if (do_pop) rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
        end
      end
      assign data_o = mem_q[rd_q];
    end
  endgenerate
endmodule

// File: rtl/pf_out_arb.sv
module pf_out_arb
  import stream_pf_pkg::*;
#(
  parameter int unsigned W = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_vld_i,
  input  logic [W-1:0] sw_line_i,
  input  logic         hw_vld_i,
  input  logic [W-1:0] hw_line_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] line_o,
  output logic         is_sw_o,
  output logic         sw_pop_o,
  output logic         hw_take_o
);
  logic     slot_free;
  pf_src_e  src_q;

  assign slot_free = !valid_o || ready_i;
  assign sw_pop_o  = slot_free && sw_vld_i;
  assign hw_take_o = slot_free && !sw_vld_i && hw_vld_i;
  assign is_sw_o   = (src_q == SRC_SW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
      src_q   <= SRC_HW;
    end else if (slot_free) begin
      valid_o <= sw_vld_i || hw_vld_i;
      if (sw_vld_i) begin
        line_o <= sw_line_i;
        src_q  <= SRC_SW;
      end else if (hw_vld_i) begin
        line_o <= hw_line_i;
        src_q  <= SRC_HW;
      end
    end
  end
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import stream_pf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned MISS_W      = 4,
  parameter int unsigned BUSY_THRESH = 8,
  parameter int unsigned PF_DIST     = 4,
  parameter int unsigned ARM_RUNS    = 2,
  parameter int unsigned HINT_DEPTH  = 4,
  localparam int unsigned LINE_W  = ADDR_W - LINE_OFF_W,
  localparam int unsigned AHEAD_W = $clog2(PF_DIST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dem_valid_i,
  input  logic [ADDR_W-1:0] dem_addr_i,
  input  logic [MISS_W-1:0] miss_cnt_i,
  input  logic              hint_valid_i,
  input  logic [ADDR_W-1:0] hint_addr_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [ADDR_W-1:0] pf_addr_o,
  output logic              pf_is_sw_o
);
  logic               armed, hw_req, hw_take, throttle;
  logic               hint_empty, hint_pop;
  logic [AHEAD_W-1:0] ahead;
  logic [LINE_W-1:0]  hw_line, hint_line, out_line;
  logic               unused_lo;

  assign unused_lo = ^{dem_addr_i[LINE_OFF_W-1:0], hint_addr_i[LINE_OFF_W-1:0]};
  assign throttle  = ({{(32-MISS_W){1'b0}}, miss_cnt_i} >= 32'(BUSY_THRESH));
  assign hw_req    = armed && (ahead < AHEAD_W'(PF_DIST)) && !throttle;

  pf_stream_tracker #(
    .LINE_W(LINE_W), .PF_DIST(PF_DIST), .ARM_RUNS(ARM_RUNS)
  ) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (dem_valid_i),
    .acc_line_i  (dem_addr_i[ADDR_W-1:LINE_OFF_W]),
    .take_i      (hw_take),
    .armed_o     (armed),
    .ahead_o     (ahead),
    .next_line_o (hw_line)
  );

  pf_hint_fifo #(
    .W(LINE_W), .DEPTH(HINT_DEPTH)
  ) u_hint (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (hint_valid_i),
    .data_i  (hint_addr_i[ADDR_W-1:LINE_OFF_W]),
    .pop_i   (hint_pop),
    .empty_o (hint_empty),
    .data_o  (hint_line)
  );

  pf_out_arb #(
    .W(LINE_W)
  ) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_vld_i  (!hint_empty),
    .sw_line_i (hint_line),
    .hw_vld_i  (hw_req),
    .hw_line_i (hw_line),
    .ready_i   (pf_ready_i),
    .valid_o   (pf_valid_o),
    .line_o    (out_line),
    .is_sw_o   (pf_is_sw_o),
    .sw_pop_o  (hint_pop),
    .hw_take_o (hw_take)
  );

  assign pf_addr_o = {out_line, {LINE_OFF_W{1'b0}}};
endmodule

// File: rtl/stream_prefetcher_chk.sv
module stream_prefetcher_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned MISS_W      = 4,
  parameter int unsigned BUSY_THRESH = 8,
  parameter int unsigned PF_DIST     = 4,
  parameter int unsigned AHEAD_W     = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [MISS_W-1:0]  miss_cnt_i,
  input logic               pf_valid_o,
  input logic               pf_ready_i,
  input logic [ADDR_W-1:0]  pf_addr_o,
  input logic               pf_is_sw_o,
  input logic               hint_empty,
  input logic               hw_take,
  input logic               armed,
  input logic [AHEAD_W-1:0] ahead
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o && !pf_ready_i |=> pf_valid_o && $stable(pf_addr_o) && $stable(pf_is_sw_o));

  assert_no_hw_when_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({{(32-MISS_W){1'b0}}, miss_cnt_i} >= 32'(BUSY_THRESH)) && (!pf_valid_o || pf_ready_i)
      |=> !(pf_valid_o && !pf_is_sw_o));

  assert_hint_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hint_empty && (!pf_valid_o || pf_ready_i) |=> pf_valid_o && pf_is_sw_o);

  assert_take_needs_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_take |-> armed);

  assert_window_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ahead) <= 32'(PF_DIST));
endmodule

bind stream_prefetcher stream_prefetcher_chk #(
  .ADDR_W(ADDR_W), .MISS_W(MISS_W), .BUSY_THRESH(BUSY_THRESH),
  .PF_DIST(PF_DIST), .AHEAD_W(AHEAD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .miss_cnt_i (miss_cnt_i),
  .pf_valid_o (pf_valid_o),
  .pf_ready_i (pf_ready_i),
  .pf_addr_o  (pf_addr_o),
  .pf_is_sw_o (pf_is_sw_o),
  .hint_empty (hint_empty),
  .hw_take    (hw_take),
  .armed      (armed),
  .ahead      (ahead)
);

// File: tb/stream_prefetcher_tb.sv
`timescale 1ns/1ps
module stream_prefetcher_tb;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dem_valid, hint_valid, pf_ready, pf_valid, pf_is_sw;
  logic [ADDR_W-1:0] dem_addr, hint_addr, pf_addr;
  logic [3:0]        miss_cnt;

  int checks = 0, fails = 0;
  logic [ADDR_W-1:0] exp_addr_q[$];
  bit                exp_sw_q[$];
  string             exp_tag_q[$];

  always #10 clk = ~clk;

  stream_prefetcher u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dem_valid_i(dem_valid), .dem_addr_i(dem_addr), .miss_cnt_i(miss_cnt),
    .hint_valid_i(hint_valid), .hint_addr_i(hint_addr),
    .pf_valid_o(pf_valid), .pf_ready_i(pf_ready),
    .pf_addr_o(pf_addr), .pf_is_sw_o(pf_is_sw)
  );

  function automatic logic [ADDR_W-1:0] la(int unsigned line);
    return ADDR_W'(line) << 6;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expect_pf(logic [ADDR_W-1:0] a, bit sw, string tag);
    exp_addr_q.push_back(a);
    exp_sw_q.push_back(sw);
    exp_tag_q.push_back(tag);
  endtask

  // monitor: pops the scoreboard on every completed handshake
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R3", "unexpected request", pf_addr, '0);
      end else begin
        logic [ADDR_W-1:0] ea;
        bit es;
        string et;
        ea = exp_addr_q.pop_front();
        es = exp_sw_q.pop_front();
        et = exp_tag_q.pop_front();
        check(pf_addr == ea && pf_is_sw == es, et, "request addr/src",
              {pf_addr[ADDR_W-1:1], pf_is_sw}, {ea[ADDR_W-1:1], es});
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; dem_valid = 0; dem_addr = '0; hint_valid = 0; hint_addr = '0;
    pf_ready = 1'b1; miss_cnt = '0;
    exp_addr_q.delete(); exp_sw_q.delete(); exp_tag_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(pf_valid == 1'b0, "R10", "valid after reset", ADDR_W'(pf_valid), '0);
  endtask

  task automatic access(int unsigned line);
    @(posedge clk); #1 dem_valid = 1'b1; dem_addr = la(line) | 32'h14;
    @(posedge clk); #1 dem_valid = 1'b0;
    repeat (12) @(posedge clk);
  endtask

  task automatic hint(logic [ADDR_W-1:0] a);
    @(posedge clk); #1 hint_valid = 1'b1; hint_addr = a;
    @(posedge clk); #1 hint_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (40) @(posedge clk);
    #1 check(exp_addr_q.size() == 0, tag, "expected requests still pending",
             ADDR_W'(exp_addr_q.size()), '0);
  endtask

  task automatic run_all();
    // R1 R2 R3: arming and sliding window
    do_reset();
    access(32'h100); access(32'h101);
    for (int i = 3; i <= 6; i++) expect_pf(la(32'h100 + i), 0, "R2");
    access(32'h102);
    expect_pf(la(32'h107), 0, "R3");
    access(32'h103);
    expect_pf(la(32'h108), 0, "R1");
    access(32'h104);
    drain("R3");

    // R4: break before and after arming
    do_reset();
    access(32'h200); access(32'h201); access(32'h900);
    access(32'h901);
    drain("R4");
    for (int i = 3; i <= 6; i++) expect_pf(la(32'h900 + i), 0, "R4");
    access(32'h902);
    access(32'h800); access(32'h500);
    drain("R4");

    // R5: repeated line ignored
    do_reset();
    access(32'h40); access(32'h41); access(32'h41);
    for (int i = 3; i <= 6; i++) expect_pf(la(32'h40 + i), 0, "R5");
    access(32'h42);
    drain("R5");

    // R6: saturation holds back hardware requests
    do_reset();
    miss_cnt = 4'd8;
    access(32'h300); access(32'h301); access(32'h302);
    drain("R6");
    for (int i = 3; i <= 6; i++) expect_pf(la(32'h300 + i), 0, "R6");
    @(posedge clk); #1 miss_cnt = 4'd7;
    drain("R6");

    // R8: hint beats pending hardware request
    do_reset();
    miss_cnt = 4'd8;
    access(32'h500); access(32'h501); access(32'h502);
    @(posedge clk); #1 pf_ready = 1'b0;
    expect_pf(32'h0ABC_DE40, 1, "R7");
    expect_pf(32'h0123_4580, 1, "R8");
    for (int i = 3; i <= 6; i++) expect_pf(la(32'h500 + i), 0, "R8");
    hint(32'h0ABC_DE47);
    repeat (3) @(posedge clk);
    hint(32'h0123_45BF);
    repeat (3) @(posedge clk);
    #1 miss_cnt = 4'd0;
    repeat (3) @(posedge clk);
    #1 pf_ready = 1'b1;
    drain("R8");

    // R7 R9: full hint queue drops, stalled port holds
    do_reset();
    @(posedge clk); #1 pf_ready = 1'b0;
    for (int i = 1; i <= 5; i++) expect_pf(la(32'h7000 + i), 1, "R7");
    hint(la(32'h7001) | 32'h3);
    repeat (3) @(posedge clk);
    for (int i = 2; i <= 6; i++) hint(la(32'h7000 + i));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(pf_valid && pf_addr == la(32'h7001) && pf_is_sw, "R9", "held request",
            pf_addr, la(32'h7001));
    end
    @(posedge clk); #1 pf_ready = 1'b1;
    drain("R7");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", '0, '0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule